// File: doc/BRIEF.md
# Floating-Point Conditional Trap Unit

This block decides whether a conditional software-trap instruction fires. On an execute strobe it evaluates one of twenty-one floating-point predicates. The predicate reads either the condition flags (negative, zero, infinity, not-a-number) or the six exception-register bits. A true predicate yields a request to stack the status and enter software exception processing. A false predicate yields a pulse that lets the sequencer move on to the next instruction.

Predicates split into two groups. Aware tests never flag unordered operands. Non-aware tests are the ordered magnitude comparisons and the infinity tests. When a non-aware test runs with the NaN flag set, the block sets two sticky bits: the unordered-condition bit of the exception register and the software-interrupt-on-operation bit of the interrupt exception register. Work is spread over two clock stages. The first stage evaluates the predicate and updates the sticky bits. The second stage issues a one-cycle stack request or next-instruction pulse. Because of this split, the sticky bits are always visible before stacking starts. When a trap is taken for a long service routine, the priority level output is raised to 3.

Top module: `fp_trap_unit`

## Requirements
- R1: Condition code values are EQ=0, NE=1, MI=2, PL=3, OR=4, UN=5, INF=6, NINF=7. Each is true respectively when Z=1, Z=0, N=1, N=0, NAN=0, NAN=1, I=1, I=0.
- R2: Codes GT=8, GE=9, LT=10, LE=11, GL=12, GLE=13 are true when their expression is 0. The expressions are: GT NAN|Z|N, GE NAN|(N&~Z), LT NAN|Z|~N, LE NAN|~(N|Z), GL NAN|Z, GLE NAN.
- R3: Codes NGT=14, NGE=15, NLT=16, NLE=17, NGL=18, NGLE=19 use the same expressions as GT, GE, LT, LE, GL and GLE, in that order, and are true when the expression is 1.
- R4: Code ERR=20 is true when any of the exception inputs UNCC, SNAN, OPERR, OVF, UNF, DZ is 1. The condition flags play no part in it.
- R5: When the strobe evaluates a code from 6 to 19 with NAN=1, uncc_o and siop_o are set on that clock edge. Codes 0 to 5 and 20 never set them.
- R6: uncc_o and siop_o stay set until clr_sticky_i is high at a clock edge. If a set and a clear land on the same edge, the set wins.
- R7: The second clock edge after an execute strobe produces a one-cycle pulse. The pulse is trap_req_o if the predicate was true and next_instr_o if it was false, never both. Outside that pulse both outputs are 0.
- R8: When a non-aware code is evaluated with NAN=1 and traps, uncc_o and siop_o are already 1 in the cycle before trap_req_o rises.
- R9: At the first edge after a strobe, ipl_o loads ipl_i. At the edge that raises trap_req_o with long_isr_i sampled high at the strobe, ipl_o becomes 3, and this takes priority over a new load. Otherwise ipl_o holds.
- R10: Codes 21 to 31 evaluate false. They give a next_instr_o pulse together with a one-cycle illegal_o pulse and touch no sticky bit.
- R11: While reset is asserted and right after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe, one per trap instruction |
| cond_sel_i | input | 5 | Condition code |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_inf_i | input | 1 | Infinity flag |
| flag_nan_i | input | 1 | Not-a-number flag |
| exc_uncc_i | input | 1 | Exception register: unordered condition |
| exc_snan_i | input | 1 | Exception register: signalling NaN |
| exc_operr_i | input | 1 | Exception register: operand error |
| exc_ovf_i | input | 1 | Exception register: overflow |
| exc_unf_i | input | 1 | Exception register: underflow |
| exc_dz_i | input | 1 | Exception register: divide by zero |
| long_isr_i | input | 1 | Service routine is long |
| ipl_i | input | 2 | Current interrupt priority level |
| clr_sticky_i | input | 1 | Synchronous clear of the sticky bits |
| trap_req_o | output | 1 | Stack-status / software exception request pulse |
| next_instr_o | output | 1 | Continue-with-next-instruction pulse |
| illegal_o | output | 1 | Unused condition code pulse |
| uncc_o | output | 1 | Sticky unordered-condition bit |
| siop_o | output | 1 | Sticky software-interrupt-on-operation bit |
| ipl_o | output | 2 | New interrupt priority level |

## Verification
Every code from 0 to 31 is run against all sixteen combinations of N, Z, I and NAN. This sweep separates each predicate from its negated twin and from the aware tests that share an operand. It also shows that NaN sets the sticky bits only for the non-aware set. ERR is swept over all 64 exception-bit patterns with the condition flags forced to values that would mislead a wrong operand choice. Back-to-back strobes, a clear that coincides with a set, and a new strobe that lands on a long-routine trap edge check the pipeline overlap and the priority-level precedence.

// File: rtl/fptrap_pkg.sv
package fptrap_pkg;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    CC_EQ   = 5'd0,  CC_NE   = 5'd1,  CC_MI   = 5'd2,  CC_PL   = 5'd3,
    CC_OR   = 5'd4,  CC_UN   = 5'd5,  CC_INF  = 5'd6,  CC_NINF = 5'd7,
    CC_GT   = 5'd8,  CC_GE   = 5'd9,  CC_LT   = 5'd10, CC_LE   = 5'd11,
    CC_GL   = 5'd12, CC_GLE  = 5'd13, CC_NGT  = 5'd14, CC_NGE  = 5'd15,
    CC_NLT  = 5'd16, CC_NLE  = 5'd17, CC_NGL  = 5'd18, CC_NGLE = 5'd19,
    CC_ERR  = 5'd20
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic inf;
    logic nan;
  } fp_flags_t;

  typedef struct packed {
    logic uncc;
    logic snan;
    logic operr;
    logic ovf;
    logic unf;
    logic dz;
  } exc_bits_t;

  localparam int unsigned STICKY_N = 2;
endpackage

// File: rtl/fptrap_cond_eval.sv
module fptrap_cond_eval
  import fptrap_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  fp_flags_t         flags_i,
  input  exc_bits_t         exc_i,
  output logic              cond_true_o,
  output logic              non_aware_o,
  output logic              illegal_o
);
  logic expr;
  logic inv;
  logic direct;
  logic use_expr;

  always_comb begin
    expr        = 1'b0;
    inv         = 1'b0;
    direct      = 1'b0;
    use_expr    = 1'b0;
    non_aware_o = 1'b0;
    illegal_o   = 1'b0;
    case (code_i)
      CC_EQ:   direct = flags_i.z;
      CC_NE:   direct = ~flags_i.z;
      CC_MI:   direct = flags_i.n;
      CC_PL:   direct = ~flags_i.n;
      CC_OR:   direct = ~flags_i.nan;
      CC_UN:   direct = flags_i.nan;
      CC_INF:  begin direct = flags_i.inf;  non_aware_o = 1'b1; end
      CC_NINF: begin direct = ~flags_i.inf; non_aware_o = 1'b1; end
      CC_ERR:  direct = |exc_i;
      CC_GT, CC_NGT: begin
        expr = flags_i.nan | flags_i.z | flags_i.n;
        use_expr = 1'b1; inv = (code_i == CC_GT);
      end
      CC_GE, CC_NGE: begin
        expr = flags_i.nan | (flags_i.n & ~flags_i.z);
        use_expr = 1'b1; inv = (code_i == CC_GE);
      end
      CC_LT, CC_NLT: begin
        expr = flags_i.nan | flags_i.z | ~flags_i.n;
        use_expr = 1'b1; inv = (code_i == CC_LT);
      end
      CC_LE, CC_NLE: begin
        expr = flags_i.nan | ~(flags_i.n | flags_i.z);
        use_expr = 1'b1; inv = (code_i == CC_LE);
      end
      CC_GL, CC_NGL: begin
        expr = flags_i.nan | flags_i.z;
        use_expr = 1'b1; inv = (code_i == CC_GL);
      end
      CC_GLE, CC_NGLE: begin
        expr = flags_i.nan;
        use_expr = 1'b1; inv = (code_i == CC_GLE);
      end
      default: illegal_o = 1'b1;
    endcase
    if (use_expr) non_aware_o = 1'b1;
    // ordered compares: true when expression is 0; negated forms when 1
    cond_true_o = use_expr ? (expr ^ inv) : direct;
  end
endmodule

// File: rtl/fptrap_sticky.sv
module fptrap_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;  // set wins over clear
      else if (clr_i)     q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fptrap_seq.sv
module fptrap_seq #(
  parameter int unsigned IPL_W    = 2,
  parameter int unsigned LONG_IPL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic             cond_true_i,
  input  logic             illegal_i,
  input  logic             long_isr_i,
  input  logic [IPL_W-1:0] ipl_i,
  output logic             trap_req_o,
  output logic             next_instr_o,
  output logic             illegal_o,
  output logic [IPL_W-1:0] ipl_o
);
  localparam logic [IPL_W-1:0] LongIplVal = IPL_W'(LONG_IPL);

  logic s1_valid, s1_true, s1_illegal, s1_long;
  logic raise_ipl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid   <= 1'b0;
      s1_true    <= 1'b0;
      s1_illegal <= 1'b0;
      s1_long    <= 1'b0;
    end else begin
      s1_valid   <= exec_i;
      s1_true    <= exec_i & cond_true_i;
      s1_illegal <= exec_i & illegal_i;
      s1_long    <= exec_i & long_isr_i;
    end
  end

  assign raise_ipl = s1_valid & s1_true & s1_long;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_req_o   <= 1'b0;
      next_instr_o <= 1'b0;
      illegal_o    <= 1'b0;
      ipl_o        <= '0;
    end else begin
      trap_req_o   <= s1_valid & s1_true;
      next_instr_o <= s1_valid & ~s1_true;
      illegal_o    <= s1_valid & s1_illegal;
      if (raise_ipl)   ipl_o <= LongIplVal;
      else if (exec_i) ipl_o <= ipl_i;
    end
  end
endmodule

// File: rtl/fp_trap_unit.sv
module fp_trap_unit
  import fptrap_pkg::*;
#(
  parameter int unsigned IPL_W    = 2,
  parameter int unsigned LONG_IPL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [CODE_W-1:0] cond_sel_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_inf_i,
  input  logic              flag_nan_i,
  input  logic              exc_uncc_i,
  input  logic              exc_snan_i,
  input  logic              exc_operr_i,
  input  logic              exc_ovf_i,
  input  logic              exc_unf_i,
  input  logic              exc_dz_i,
  input  logic              long_isr_i,
  input  logic [IPL_W-1:0]  ipl_i,
  input  logic              clr_sticky_i,
  output logic              trap_req_o,
  output logic              next_instr_o,
  output logic              illegal_o,
  output logic              uncc_o,
  output logic              siop_o,
  output logic [IPL_W-1:0]  ipl_o
);
  fp_flags_t             flags;
  exc_bits_t             exc;
  logic                  cond_true, non_aware, illegal;
  logic                  unord_hit;
  logic [STICKY_N-1:0]   sticky_q;

  assign flags = '{n: flag_n_i, z: flag_z_i, inf: flag_inf_i, nan: flag_nan_i};
  assign exc   = '{uncc: exc_uncc_i, snan: exc_snan_i, operr: exc_operr_i,
                   ovf: exc_ovf_i, unf: exc_unf_i, dz: exc_dz_i};

  fptrap_cond_eval u_eval (
    .code_i      (cond_sel_i),
    .flags_i     (flags),
    .exc_i       (exc),
    .cond_true_o (cond_true),
    .non_aware_o (non_aware),
    .illegal_o   (illegal)
  );

  // stage 1 flag update precedes the stage 2 stack request
  assign unord_hit = exec_i & non_aware & flag_nan_i;

  fptrap_sticky #(.N(STICKY_N)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({STICKY_N{unord_hit}}),
    .clr_i  (clr_sticky_i),
    .q_o    (sticky_q)
  );

  assign uncc_o = sticky_q[0];
  assign siop_o = sticky_q[1];

  fptrap_seq #(.IPL_W(IPL_W), .LONG_IPL(LONG_IPL)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .exec_i       (exec_i),
    .cond_true_i  (cond_true),
    .illegal_i    (illegal),
    .long_isr_i   (long_isr_i),
    .ipl_i        (ipl_i),
    .trap_req_o   (trap_req_o),
    .next_instr_o (next_instr_o),
    .illegal_o    (illegal_o),
    .ipl_o        (ipl_o)
  );
endmodule

// File: rtl/fp_trap_unit_chk.sv
module fp_trap_unit_chk #(
  parameter int unsigned IPL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exec_i,
  input logic [4:0]       cond_sel_i,
  input logic             flag_nan_i,
  input logic             long_isr_i,
  input logic             clr_sticky_i,
  input logic             trap_req_o,
  input logic             next_instr_o,
  input logic             illegal_o,
  input logic             uncc_o,
  input logic             siop_o,
  input logic [IPL_W-1:0] ipl_o
);
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_req_o && next_instr_o)); // R7

  AST_PULSE_AFTER_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o || next_instr_o) |-> $past(exec_i, 2)); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uncc_o && siop_o && !clr_sticky_i) |=> (uncc_o && siop_o)); // R6

  AST_FLAGS_BEFORE_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o && $past(exec_i && flag_nan_i && cond_sel_i >= 5'd6 && cond_sel_i <= 5'd19, 2))
      |-> $past(uncc_o && siop_o)); // R8

  AST_LONG_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o && $past(long_isr_i, 2)) |-> (ipl_o == IPL_W'(3))); // R9

  AST_ILLEGAL_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (next_instr_o && !trap_req_o)); // R10
endmodule

bind fp_trap_unit fp_trap_unit_chk #(.IPL_W(IPL_W)) u_chk (.*);

// File: tb/sim_fp_trap_unit.sv
`timescale 1ns/1ps
module sim_fp_trap_unit;
  localparam int C_EQ=0, C_NE=1, C_MI=2, C_PL=3, C_OR=4, C_UN=5, C_INF=6, C_NINF=7,
                 C_GT=8, C_GE=9, C_LT=10, C_LE=11, C_GL=12, C_GLE=13,
                 C_NGT=14, C_NGE=15, C_NLT=16, C_NLE=17, C_NGL=18, C_NGLE=19, C_ERR=20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exec = 1'b0, fn = 1'b0, fz = 1'b0, fi = 1'b0, fnan = 1'b0;
  logic [4:0] code = '0;
  logic [5:0] excv = '0;
  logic lng = 1'b0, clr = 1'b0;
  logic [1:0] ipl_in = '0;
  logic trap, nxt, ill, uncc, siop;
  logic [1:0] ipl;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  fp_trap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .cond_sel_i(code),
    .flag_n_i(fn), .flag_z_i(fz), .flag_inf_i(fi), .flag_nan_i(fnan),
    .exc_uncc_i(excv[5]), .exc_snan_i(excv[4]), .exc_operr_i(excv[3]),
    .exc_ovf_i(excv[2]), .exc_unf_i(excv[1]), .exc_dz_i(excv[0]),
    .long_isr_i(lng), .ipl_i(ipl_in), .clr_sticky_i(clr),
    .trap_req_o(trap), .next_instr_o(nxt), .illegal_o(ill),
    .uncc_o(uncc), .siop_o(siop), .ipl_o(ipl)
  );

  function automatic bit pred(int c, bit n, bit z, bit i, bit nan, logic [5:0] e);
    case (c)
      C_EQ: return z;            C_NE: return !z;
      C_MI: return n;            C_PL: return !n;
      C_OR: return !nan;         C_UN: return nan;
      C_INF: return i;           C_NINF: return !i;
      C_GT: return (nan||z||n) == 0;        C_NGT: return (nan||z||n) == 1;
      C_GE: return (nan||(n&&!z)) == 0;     C_NGE: return (nan||(n&&!z)) == 1;
      C_LT: return (nan||z||!n) == 0;       C_NLT: return (nan||z||!n) == 1;
      C_LE: return (nan||!(n||z)) == 0;     C_NLE: return (nan||!(n||z)) == 1;
      C_GL: return (nan||z) == 0;           C_NGL: return (nan||z) == 1;
      C_GLE: return nan == 0;               C_NGLE: return nan == 1;
      C_ERR: return e != 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_nonaware(int c);
    return (c >= C_INF && c <= C_NGLE);
  endfunction

  // reference model: queue of in-flight strobes, one entry per cycle
  typedef struct { bit v; bit t; bit il; bit lg; } stage_t;
  stage_t pipe[$];
  bit m_uncc, m_siop, m_trap, m_next, m_ill;
  int m_ipl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe.delete();
      m_uncc = 0; m_siop = 0; m_trap = 0; m_next = 0; m_ill = 0; m_ipl = 0;
    end else begin
      stage_t s, old;
      bit hit;
      hit = exec && is_nonaware(code) && fnan;
      if (hit) begin m_uncc = 1; m_siop = 1; end
      else if (clr) begin m_uncc = 0; m_siop = 0; end
      old = (pipe.size() > 0) ? pipe.pop_front() : '{0, 0, 0, 0};
      m_trap = old.v && old.t;
      m_next = old.v && !old.t;
      m_ill  = old.v && old.il;
      if (old.v && old.t && old.lg) m_ipl = 3;
      else if (exec) m_ipl = ipl_in;
      s.v = exec; s.t = exec && pred(code, fn, fz, fi, fnan, excv);
      s.il = exec && (code > C_ERR); s.lg = exec && lng;
      pipe.push_back(s);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t code=%0d)", tag, act, exp, $time, code);
    end
  endtask

  task automatic compare();
    chk("R7/R1/R2/R3/R4 trap_req_o", trap, m_trap);
    chk("R7/R10 next_instr_o", nxt, m_next);
    chk("R10 illegal_o", ill, m_ill);
    chk("R5/R6 uncc_o", uncc, m_uncc);
    chk("R5/R6 siop_o", siop, m_siop);
    chk("R9 ipl_o", ipl, m_ipl);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic drive(bit ex, int c, logic [3:0] f, logic [5:0] e, bit l, logic [1:0] p, bit cl);
    exec = ex; code = 5'(c); {fn, fz, fi, fnan} = f; excv = e; lng = l; ipl_in = p; clr = cl;
  endtask

  task automatic run_one(int c, logic [3:0] f, logic [5:0] e, bit l, logic [1:0] p);
    drive(1, c, f, e, l, p, 0);
    step();
    drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 0);
    step(); step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11: outputs zero during reset
    chk("R11 reset trap", trap, 0); chk("R11 reset next", nxt, 0);
    chk("R11 reset uncc", uncc, 0); chk("R11 reset siop", siop, 0);
    chk("R11 reset ipl", ipl, 0);   chk("R11 reset illegal", ill, 0);
    rst_n = 1'b1;
    step();

    // R1 R2 R3 R5 R10: every code against every flag pattern
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 16; f++) begin
        run_one(c, 4'(f), 6'h0, bit'((c + f) % 2), 2'(f % 3));
        if ((f % 5) == 4) begin
          drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 1);  // R6 clear
          step();
          drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 0);
          step();
        end
      end
    end

    // R4: ERR over all exception patterns, flags set to mislead
    for (int e = 0; e < 64; e++) begin
      run_one(C_ERR, (e % 2) ? 4'hF : 4'h4, 6'(e), 1, 2'd1);
    end

    // R6: set and clear on the same edge, set wins
    drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 1); step();
    drive(1, C_NGT, 4'h1, 6'h0, 0, 2'd2, 1); step();
    drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 0); step(); step();
    chk("R6 set beats clear", uncc, 1);

    // R7 R9: back-to-back strobes; new strobe on a long-trap edge
    drive(1, C_EQ, 4'h4, 6'h0, 1, 2'd1, 0); step();
    drive(1, C_NE, 4'h4, 6'h0, 0, 2'd2, 0); step();
    drive(1, C_UN, 4'h1, 6'h0, 1, 2'd0, 0); step();
    drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 0);
    for (int k = 0; k < 4; k++) step();
    chk("R9 long trap level", ipl, 3);

    // R8: flags set before the stack request on a non-aware NaN trap
    drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 1); step();
    drive(1, C_NGLE, 4'h1, 6'h0, 1, 2'd0, 0); step();
    drive(0, 0, 4'h0, 6'h0, 0, 2'd0, 0);
    chk("R8 uncc before stack", uncc, 1);
    chk("R8 no stack yet", trap, 0);
    step();
    chk("R8 stack after flags", trap, 1);
    step();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule